// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches the loads a core executes. Each load arrives with its byte address and the program counter of the instruction that issued it. For every instruction the block keeps a small history record: the last address that instruction touched, the address step it has been taking, and a saturating confidence count. When an instruction has repeated the same non-zero step often enough, each further load from it starts a burst of prefetch requests. The burst covers the next several positions along that step, so data is requested well before the core reaches it.

The history sits in a direct-mapped table. One slice of the program counter picks the entry and the upper bits serve as a tag. Prefetch requests leave as cache-block numbers, one per cycle, under a valid/ready handshake. A newer confident load replaces whatever is left of the older burst. Within a burst, a request that would repeat the block just requested is dropped, which matters when the step is smaller than a cache block.

Top module: `stride_pf_top`

## Requirements
- R1: After reset, `pf_valid` is low and every table entry is empty, so the first load seen from any instruction never starts a burst.
- R2: The table entry is picked by `ld_pc[5:2]` and tagged with `ld_pc[31:6]`. A load whose tag differs from the stored tag overwrites the entry with that load's address, a step of 0 and confidence 0, and never starts a burst.
- R3: The observed step is `ld_addr` minus the entry's last address, in 32-bit two's complement, so negative steps are learned as well. Every load that hits its entry makes its own address the entry's last address.
- R4: Confidence is a 2-bit count that saturates at 3. A load whose observed step equals the stored step raises it by one, and a burst starts when the raised value is 2 or more. With a constant step, the fourth load of a new instruction is therefore the first to start a burst.
- R5: A load whose observed step differs from the stored step lowers the confidence by one and keeps the stored step. Only when the confidence is already 0 is the stored step replaced by the observed one.
- R6: A stored step of zero never starts a burst, whatever the confidence.
- R7: A burst started by a load at byte address A with step N carries the addresses A+N, A+2N, ... up to A+4N (the depth parameter defaults to 4), in that order. Each is output as its block number `addr[31:6]` (64-byte blocks).
- R8: One request transfers on each rising edge where `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged.
- R9: A load that starts a burst discards every request of the previous burst that has not yet transferred, including one being presented at that moment.
- R10: Within a burst, an address whose block equals the block of the request transferred just before it is skipped, so no block is requested twice in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_pc | input | 32 | Program counter of the load instruction |
| ld_addr | input | 32 | Byte address of the load |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_addr | output | 26 | Block number of the presented request |
| pf_ready | input | 1 | Downstream accepts the presented request |

## Verification
On every cycle the assertions check the handshake hold under backpressure, that no block repeats back to back, that a burst never exceeds its depth, that tag misses and zero steps never start a burst, and that reset leaves the output idle. Whether the table learns the right step, counts confidence the right way, and emits the exact address sequence is visible only through the bench's scenarios. These cover constant, negative, sub-block and zero steps, aliasing instructions, step changes at high confidence and a burst overridden under backpressure, all compared against a model of the requirements. Randomized multi-instruction streams then mix these cases together.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    localparam int CONF_W    = 2;
    localparam int CONF_FIRE = 2;

    typedef enum logic [1:0] {
        TR_ALLOC    = 2'd0,
        TR_ADOPT    = 2'd1,
        TR_MATCH    = 2'd2,
        TR_MISMATCH = 2'd3
    } train_kind_e;

    function automatic logic [CONF_W-1:0] conf_up(input logic [CONF_W-1:0] c);
        return (c == {CONF_W{1'b1}}) ? c : c + 1'b1;
    endfunction

    function automatic logic [CONF_W-1:0] conf_down(input logic [CONF_W-1:0] c);
        return (c == '0) ? c : c - 1'b1;
    endfunction

endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
    import stride_pf_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_last,
    output logic [ADDR_W-1:0] rd_stride,
    output logic [CONF_W-1:0] rd_conf,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_last,
    input  logic [ADDR_W-1:0] wr_stride,
    input  logic [CONF_W-1:0] wr_conf
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] stride;
        logic [CONF_W-1:0] conf;
    } entry_t;

    entry_t tbl_q [ENTRIES];
    entry_t tbl_d [ENTRIES];

    // read port: the entry as it stood before this cycle's update
    assign rd_vld    = tbl_q[rd_idx].vld;
    assign rd_tag    = tbl_q[rd_idx].tag;
    assign rd_last   = tbl_q[rd_idx].last;
    assign rd_stride = tbl_q[rd_idx].stride;
    assign rd_conf   = tbl_q[rd_idx].conf;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en) begin
            tbl_d[rd_idx].vld    = 1'b1;
            tbl_d[rd_idx].tag    = wr_tag;
            tbl_d[rd_idx].last   = wr_last;
            tbl_d[rd_idx].stride = wr_stride;
            tbl_d[rd_idx].conf   = wr_conf;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                tbl_q[i] <= '0;
            end else begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

endmodule

// File: rtl/stride_pf_train.sv
module stride_pf_train
    import stride_pf_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32
) (
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_vld,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_last,
    input  logic [ADDR_W-1:0] rd_stride,
    input  logic [CONF_W-1:0] rd_conf,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_last,
    output logic [ADDR_W-1:0] wr_stride,
    output logic [CONF_W-1:0] wr_conf,
    output logic              hit,
    output train_kind_e       kind,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_stride
);

    logic [ADDR_W-1:0] observed;
    logic              same_step;

    assign hit       = rd_vld && (rd_tag == ld_tag);
    assign observed  = ld_addr - rd_last;
    assign same_step = (observed == rd_stride);

    always_comb begin
        wr_en     = ld_valid;
        wr_tag    = ld_tag;
        wr_last   = ld_addr;
        wr_stride = rd_stride;
        wr_conf   = rd_conf;
        if (!hit) begin
            kind      = TR_ALLOC;
            wr_stride = '0;
            wr_conf   = '0;
        end else if (same_step) begin
            kind    = TR_MATCH;
            wr_conf = conf_up(rd_conf);
        end else if (rd_conf == '0) begin
            kind      = TR_ADOPT;
            wr_stride = observed;
        end else begin
            kind    = TR_MISMATCH;
            wr_conf = conf_down(rd_conf);
        end
    end

    assign fire = ld_valid && (kind == TR_MATCH)
                  && (wr_conf >= CONF_W'(CONF_FIRE))
                  && (rd_stride != '0);
    assign fire_stride = rd_stride;

endmodule

// File: rtl/stride_pf_gen.sv
module stride_pf_gen #(
    parameter int ADDR_W  = 32,
    parameter int BLK_OFF = 6,
    parameter int DEPTH   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         stride,
    output logic                      pf_valid,
    output logic [ADDR_W-BLK_OFF-1:0] pf_addr,
    input  logic                      pf_ready
);

    localparam int BLK_W = ADDR_W - BLK_OFF;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic [CNT_W-1:0]  remain;
        logic              have_last;
        logic [BLK_W-1:0]  last_blk;
    } gen_t;

    gen_t st_q, st_d;

    logic [BLK_W-1:0] cand_blk;
    logic             dup;
    logic             advance;

    assign cand_blk = st_q.addr[ADDR_W-1:BLK_OFF];
    assign dup      = st_q.have_last && (cand_blk == st_q.last_blk);
    assign pf_valid = st_q.active && !dup;
    assign pf_addr  = cand_blk;
    assign advance  = st_q.active && (dup || pf_ready);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.active    = 1'b1;
            st_d.addr      = base + stride;
            st_d.stride    = stride;
            st_d.remain    = CNT_W'(DEPTH);
            st_d.have_last = 1'b0;
            st_d.last_blk  = '0;
        end else if (advance) begin
            if (!dup) begin
                st_d.have_last = 1'b1;
                st_d.last_blk  = cand_blk;
            end
            st_d.addr = st_q.addr + st_q.stride;
            if (st_q.remain == CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.remain = '0;
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stride_pf_top.sv
module stride_pf_top
    import stride_pf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int BLK_OFF = 6,
    parameter int DEPTH   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_valid,
    input  logic [PC_W-1:0]           ld_pc,
    input  logic [ADDR_W-1:0]         ld_addr,
    output logic                      pf_valid,
    output logic [ADDR_W-BLK_OFF-1:0] pf_addr,
    input  logic                      pf_ready
);

    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = PC_W - TAG_LO;

    logic [IDX_W-1:0]  ld_idx;
    logic [TAG_W-1:0]  ld_tag;

    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_last;
    logic [ADDR_W-1:0] rd_stride;
    logic [CONF_W-1:0] rd_conf;

    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_last;
    logic [ADDR_W-1:0] wr_stride;
    logic [CONF_W-1:0] wr_conf;

    logic              tbl_hit;
    train_kind_e       tr_kind;
    logic              gen_load;
    logic [ADDR_W-1:0] gen_stride;

    assign ld_idx = ld_pc[TAG_LO-1:IDX_LO];
    assign ld_tag = ld_pc[PC_W-1:TAG_LO];

    stride_pf_table #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (ld_idx),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_last   (rd_last),
        .rd_stride (rd_stride),
        .rd_conf   (rd_conf),
        .wr_en     (wr_en),
        .wr_tag    (wr_tag),
        .wr_last   (wr_last),
        .wr_stride (wr_stride),
        .wr_conf   (wr_conf)
    );

    stride_pf_train #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_train (
        .ld_valid    (ld_valid),
        .ld_tag      (ld_tag),
        .ld_addr     (ld_addr),
        .rd_vld      (rd_vld),
        .rd_tag      (rd_tag),
        .rd_last     (rd_last),
        .rd_stride   (rd_stride),
        .rd_conf     (rd_conf),
        .wr_en       (wr_en),
        .wr_tag      (wr_tag),
        .wr_last     (wr_last),
        .wr_stride   (wr_stride),
        .wr_conf     (wr_conf),
        .hit         (tbl_hit),
        .kind        (tr_kind),
        .fire        (gen_load),
        .fire_stride (gen_stride)
    );

    stride_pf_gen #(
        .ADDR_W  (ADDR_W),
        .BLK_OFF (BLK_OFF),
        .DEPTH   (DEPTH)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gen_load),
        .base     (ld_addr),
        .stride   (gen_stride),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr),
        .pf_ready (pf_ready)
    );

endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
    parameter int ADDR_W  = 32,
    parameter int BLK_OFF = 6,
    parameter int DEPTH   = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ld_valid,
    input logic                      hit,
    input logic                      trig,
    input logic [ADDR_W-1:0]         trig_stride,
    input logic                      pf_valid,
    input logic [ADDR_W-BLK_OFF-1:0] pf_addr,
    input logic                      pf_ready
);

    localparam int CNT_W = $clog2(DEPTH + 1) + 1;

    logic [CNT_W-1:0] xfer_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_cnt_q <= '0;
        end else if (trig) begin
            xfer_cnt_q <= '0;
        end else if (pf_valid && pf_ready) begin
            xfer_cnt_q <= xfer_cnt_q + 1'b1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    p_miss_no_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |-> !trig);

    p_zero_step_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (trig_stride != '0));

    p_burst_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |-> (xfer_cnt_q < CNT_W'(DEPTH)));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !trig) |=> (pf_valid && $stable(pf_addr)));

    p_no_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !trig) |=> !(pf_valid && (pf_addr == $past(pf_addr))));

endmodule

bind stride_pf_top stride_pf_checker #(
    .ADDR_W  (ADDR_W),
    .BLK_OFF (BLK_OFF),
    .DEPTH   (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .hit         (tbl_hit),
    .trig        (gen_load),
    .trig_stride (gen_stride),
    .pf_valid    (pf_valid),
    .pf_addr     (pf_addr),
    .pf_ready    (pf_ready)
);

// File: tb/stride_pf_top_test.sv
module stride_pf_top_test;

    localparam int M     = 4;
    localparam int BOFF  = 6;
    localparam int NENT  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_addr = '0;
    logic        pf_valid;
    logic [25:0] pf_addr;
    logic        pf_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model of the history table
    logic        m_vld    [NENT];
    logic [25:0] m_tag    [NENT];
    logic [31:0] m_last   [NENT];
    logic [31:0] m_stride [NENT];
    int          m_conf   [NENT];

    logic [25:0] exp_q [M];
    int          exp_n;

    always #2.5 clk = ~clk;

    stride_pf_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_pc    (ld_pc),
        .ld_addr  (ld_addr),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr),
        .pf_ready (pf_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Applies R2..R7 and R10 to the model; fills exp_q with the expected burst.
    task automatic model_step(input logic [31:0] pc, input logic [31:0] addr);
        int          i;
        logic [25:0] t;
        logic [31:0] obs;
        logic [31:0] s;
        logic [31:0] a;
        logic [25:0] lastb;
        bit          have;
        bit          go;
        i = int'(pc[5:2]);
        t = pc[31:6];
        exp_n = 0;
        go = 1'b0;
        s = m_stride[i];
        if (!m_vld[i] || m_tag[i] != t) begin
            m_vld[i] = 1'b1; m_tag[i] = t; m_stride[i] = '0; m_conf[i] = 0;
        end else begin
            obs = addr - m_last[i];
            if (obs == m_stride[i]) begin
                if (m_conf[i] < 3) m_conf[i]++;
                go = (m_conf[i] >= 2) && (m_stride[i] != 0);
            end else if (m_conf[i] == 0) begin
                m_stride[i] = obs;
            end else begin
                m_conf[i]--;
            end
        end
        m_last[i] = addr;
        if (go) begin
            a = addr; have = 1'b0; lastb = '0;
            for (int k = 0; k < M; k++) begin
                a = a + s;
                if (!have || a[31:BOFF] != lastb) begin
                    exp_q[exp_n] = a[31:BOFF];
                    exp_n++;
                    lastb = a[31:BOFF];
                    have = 1'b1;
                end
            end
        end
    endtask

    task automatic drive_load(input logic [31:0] pc, input logic [31:0] addr);
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = pc; ld_addr = addr;
        model_step(pc, addr);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Collects the burst that follows a load and compares it to the model.
    task automatic collect(input string req, input int ready_pct);
        int k;
        k = 0;
        for (int c = 0; c < 6 * M + 6; c++) begin
            pf_ready = ($urandom_range(99) < ready_pct);
            #1;
            if (pf_valid && pf_ready) begin
                if (k < exp_n) begin
                    check(pf_addr == exp_q[k], req, 32'(pf_addr), 32'(exp_q[k]));
                end else begin
                    check(1'b0, req, 32'(pf_addr), 32'hFFFF_FFFF);
                end
                k++;
            end
            @(negedge clk);
        end
        pf_ready = 1'b0;
        check(k == exp_n, req, 32'(k), 32'(exp_n));
    endtask

    task automatic load_and_check(input logic [31:0] pc, input logic [31:0] addr,
                                  input string req);
        drive_load(pc, addr);
        collect(req, 80);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] cur [6];
        logic [31:0] stp [6];
        logic [25:0] held;
        void'($urandom(32'd20230526));
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_last[i] = '0; m_stride[i] = '0; m_conf[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: idle output during and right after reset
        check(pf_valid == 1'b0, "R1 reset", 32'(pf_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid == 1'b0, "R1 post-reset", 32'(pf_valid), 32'd0);
        load_and_check(32'h0040_0100, 32'h0001_0000, "R1 first load");

        // R4/R7: constant step 64, burst starts on fourth load
        a = 32'h0002_0000;
        load_and_check(32'h0040_0004, a, "R4 load1");
        load_and_check(32'h0040_0004, a + 64, "R4 load2");
        load_and_check(32'h0040_0004, a + 128, "R4 load3");
        load_and_check(32'h0040_0004, a + 192, "R4 R7 load4 burst");
        load_and_check(32'h0040_0004, a + 256, "R7 load5 burst");

        // R3: negative step of -128
        a = 32'h0003_0000;
        for (int j = 0; j < 5; j++) load_and_check(32'h0040_0008, a - 32'(128 * j), "R3 negative");

        // R10: step 8 bytes, several addresses share a block
        a = 32'h0004_0030;
        for (int j = 0; j < 5; j++) load_and_check(32'h0040_000C, a + 32'(8 * j), "R10 sub-block");

        // R6: zero step repeats never prefetch
        for (int j = 0; j < 6; j++) load_and_check(32'h0040_0010, 32'h0005_0000, "R6 zero step");

        // R2: two instructions aliasing on index 5 with different tags
        for (int j = 0; j < 4; j++) begin
            load_and_check(32'h0040_0014, 32'h0006_0000 + 32'(64 * j), "R2 alias a");
            load_and_check(32'h0080_0014, 32'h0007_0000 + 32'(64 * j), "R2 alias b");
        end

        // R5: saturate, then change step; stored step survives one mismatch
        a = 32'h0008_0000;
        for (int j = 0; j < 6; j++) load_and_check(32'h0040_0018, a + 32'(256 * j), "R5 train");
        a = a + 32'(256 * 5);
        load_and_check(32'h0040_0018, a + 64, "R5 mismatch");
        load_and_check(32'h0040_0018, a + 64 + 256, "R5 old step kept");

        // R8/R9: backpressure, then a newer burst replaces the stalled one
        a = 32'h0009_0000;
        for (int j = 0; j < 3; j++) load_and_check(32'h0040_001C, a + 32'(64 * j), "R9 train a");
        for (int j = 0; j < 3; j++) load_and_check(32'h0040_0020, 32'h000A_0000 + 32'(128 * j), "R9 train b");
        pf_ready = 1'b0;
        drive_load(32'h0040_001C, a + 192);
        #1;
        check(pf_valid == 1'b1, "R8 valid under stall", 32'(pf_valid), 32'd1);
        check(pf_addr == exp_q[0], "R8 first addr", 32'(pf_addr), 32'(exp_q[0]));
        held = pf_addr;
        repeat (3) @(negedge clk);
        #1;
        check(pf_valid == 1'b1 && pf_addr == held, "R8 held", 32'(pf_addr), 32'(held));
        drive_load(32'h0040_0020, 32'h000A_0000 + 32'(128 * 3));
        collect("R9 replaced burst", 100);

        // random multi-instruction streams
        for (int i = 0; i < 6; i++) begin
            cur[i] = $urandom();
            stp[i] = 32'($signed($urandom_range(64)) - 32) * 8;
        end
        for (int e = 0; e < 250; e++) begin
            int i;
            i = $urandom_range(5);
            if ($urandom_range(99) < 12) stp[i] = 32'($signed($urandom_range(64)) - 32) * 8;
            cur[i] = cur[i] + stp[i];
            load_and_check(32'h0040_0000 + 32'(4 * i) + ((i == 5) ? 32'h40 : 32'h0),
                           cur[i], "R3 R4 R5 R7 R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule